// File: doc/BRIEF.md
# Local Alignment Traceback Walker

This block recovers the aligned character pairs of a local sequence alignment once a scoring engine has filled its score and direction matrices. A single start pulse supplies the coordinates of the best-scoring cell. The walker then follows the direction code stored in each cell back towards the top-left corner. For every step it emits one pair of characters, and it uses a dash symbol wherever one sequence advances and the other does not.

The block reads the shared matrix store and both sequence buffers through one request port. Read data arrives one cycle after the request. Pairs leave on a valid/ready stream in walk order, so the pair at the best-scoring end comes first and the pair nearest the start of the alignment comes last. The final pair carries a last flag, and a one-cycle done pulse follows it. Reversing the strings and moving them to the host are left to the consumer.

Top module: `align_traceback`

## Requirements
- R1: Direction codes are 2'b00 stop, 2'b01 diagonal, 2'b10 up, 2'b11 left. A diagonal cell emits (row char, column char) and moves to (row-1, col-1). An up cell emits (row char, 8'h2D) and moves to (row-1, col). A left cell emits (8'h2D, column char) and moves to (row, col-1).
- R2: The first read after an accepted start addresses the start coordinates. Pairs are emitted in walk order, beginning with the start cell.
- R3: A cell whose score is zero emits no pair and ends the walk.
- R4: A cell holding the stop code emits no pair and ends the walk, even if its score is nonzero.
- R5: No read is ever issued for a cell in row 0 or column 0. A move that lands in row 0 or column 0 ends the walk after the current pair. A start in row 0 or column 0 produces no pairs.
- R6: When the start cell ends the walk at once, no pair is emitted and done still pulses.
- R7: While out_valid is high and out_ready is low, the pair and the last flag hold steady.
- R8: out_last is high on the final pair of a walk and low on every other pair.
- R9: done is high for exactly one cycle: the cycle after the last pair is accepted, or the cycle after the walk ends with no pairs.
- R10: A start pulse that arrives while a walk is in progress has no effect on the pairs being emitted.
- R11: At most one read is outstanding at a time. Read data is taken in the cycle after mem_rd_en.
- R12: After reset, out_valid, done and mem_rd_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk at start_row/start_col (taken only when idle) |
| start_row | input | IDX_W | Row of the best-scoring cell |
| start_col | input | IDX_W | Column of the best-scoring cell |
| mem_rd_en | output | 1 | Read request to matrix and sequence buffers |
| mem_rd_row | output | IDX_W | Row of the requested cell |
| mem_rd_col | output | IDX_W | Column of the requested cell |
| mem_dir | input | 2 | Direction code of the requested cell, one cycle later |
| mem_score | input | SCORE_W | Score of the requested cell, one cycle later |
| mem_row_ch | input | CHAR_W | Row-sequence character at the requested row |
| mem_col_ch | input | CHAR_W | Column-sequence character at the requested column |
| out_valid | output | 1 | An aligned pair is presented |
| out_ready | input | 1 | Consumer accepts the pair |
| out_row_ch | output | CHAR_W | Row-sequence side of the pair, or 8'h2D for a gap |
| out_col_ch | output | CHAR_W | Column-sequence side of the pair, or 8'h2D for a gap |
| out_last | output | 1 | Marks the final pair of the walk |
| done | output | 1 | One-cycle pulse when the walk is finished |

## Verification
Several properties are checked on every cycle: a stalled pair stays unchanged, done follows acceptance of the last pair and lasts one cycle, reads never overlap, and no read ever touches row 0 or column 0. Other behaviour is visible only through the bench's scenarios, which compare against a reference walk: the exact character pairs and gap positions, the choice of terminating cell (zero score, stop code, or border), the empty walk, and a start pulse that arrives mid-walk.

// File: rtl/atb_pkg.sv
package atb_pkg;

    parameter int IDX_W   = 6;
    parameter int SCORE_W = 10;
    parameter int CHAR_W  = 8;

    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [SCORE_W-1:0] score_t;
    typedef logic [CHAR_W-1:0]  char_t;

    localparam char_t GAP_SYM = char_t'(45);

    // Encoding shared with the scoring engine that writes the direction matrix.
    typedef enum logic [1:0] {
        DIR_STOP = 2'b00,
        DIR_DIAG = 2'b01,
        DIR_UP   = 2'b10,
        DIR_LEFT = 2'b11
    } dir_e;

    typedef struct packed {
        idx_t row;
        idx_t col;
    } coord_t;

    typedef struct packed {
        coord_t at;
        dir_e   dir;
        char_t  rch;
        char_t  cch;
    } cell_t;

    typedef struct packed {
        char_t rch;
        char_t cch;
    } pair_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_CATCH,
        ST_SHOW,
        ST_FIN
    } state_e;

    // Character pair produced by a non-terminal cell.
    function automatic pair_t pair_of(cell_t c);
        pair_t p;
        case (c.dir)
            DIR_DIAG: begin p.rch = c.rch;   p.cch = c.cch;   end
            DIR_UP:   begin p.rch = c.rch;   p.cch = GAP_SYM; end
            DIR_LEFT: begin p.rch = GAP_SYM; p.cch = c.cch;   end
            default:  begin p.rch = GAP_SYM; p.cch = GAP_SYM; end
        endcase
        return p;
    endfunction

    // Coordinates of the cell the walk moves to.
    function automatic coord_t step_from(cell_t c);
        coord_t n;
        n = c.at;
        case (c.dir)
            DIR_DIAG: begin n.row = c.at.row - 1'b1; n.col = c.at.col - 1'b1; end
            DIR_UP:   n.row = c.at.row - 1'b1;
            DIR_LEFT: n.col = c.at.col - 1'b1;
            default:  n = c.at;
        endcase
        return n;
    endfunction

    function automatic logic on_border(coord_t p);
        return (p.row == '0) || (p.col == '0);
    endfunction

    function automatic logic ends_walk(score_t s, dir_e d);
        return (s == '0) || (d == DIR_STOP);
    endfunction

endpackage

// File: rtl/atb_cell_capture.sv
module atb_cell_capture
    import atb_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_en,
    input  coord_t       probe_at,
    input  logic [1:0]   rsp_dir,
    input  score_t       rsp_score,
    input  char_t        rsp_rch,
    input  char_t        rsp_cch,
    output cell_t        in_cell,
    output logic         in_stop,
    output cell_t        held
);

    // Read data joined with the address that was requested one cycle earlier.
    always_comb begin
        in_cell.at  = probe_at;
        in_cell.dir = dir_e'(rsp_dir);
        in_cell.rch = rsp_rch;
        in_cell.cch = rsp_cch;
    end

    assign in_stop = ends_walk(rsp_score, dir_e'(rsp_dir));

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (cap_en) begin
            held <= in_cell;
        end
    end

endmodule

// File: rtl/atb_step_decode.sv
module atb_step_decode
    import atb_pkg::*;
(
    input  cell_t  cur,
    output pair_t  pair,
    output coord_t nxt,
    output logic   nxt_edge
);

    always_comb begin
        pair     = pair_of(cur);
        nxt      = step_from(cur);
        nxt_edge = on_border(nxt);
    end

endmodule

// File: rtl/atb_ctrl.sv
module atb_ctrl
    import atb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  coord_t start_at,
    input  cell_t  in_cell,
    input  logic   in_stop,
    input  cell_t  held,
    input  coord_t nxt,
    input  logic   nxt_edge,
    input  logic   out_ready,
    output logic   rd_en,
    output coord_t rd_at,
    output logic   cap_en,
    output cell_t  cur,
    output logic   out_valid,
    output logic   out_last,
    output logic   done
);

    state_e st;
    coord_t probe;
    logic   have_cur;
    logic   last_q;

    // Read issue is combinational so the request leaves in the deciding cycle.
    always_comb begin
        rd_en  = 1'b0;
        rd_at  = probe;
        cap_en = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start && !on_border(start_at)) begin
                    rd_en = 1'b1;
                    rd_at = start_at;
                end
            end
            ST_PLAN: begin
                if (!nxt_edge) begin
                    rd_en = 1'b1;
                    rd_at = nxt;
                end
            end
            ST_CATCH: cap_en = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            probe    <= '0;
            cur      <= '0;
            have_cur <= 1'b0;
            last_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        have_cur <= 1'b0;
                        last_q   <= 1'b0;
                        if (on_border(start_at)) begin
                            st <= ST_FIN;
                        end else begin
                            probe <= start_at;
                            st    <= ST_CATCH;
                        end
                    end
                end
                ST_PLAN: begin
                    if (nxt_edge) begin
                        last_q <= 1'b1;
                        st     <= ST_SHOW;
                    end else begin
                        probe <= nxt;
                        st    <= ST_CATCH;
                    end
                end
                ST_CATCH: begin
                    if (!have_cur) begin
                        if (in_stop) begin
                            st <= ST_FIN;
                        end else begin
                            cur      <= in_cell;
                            have_cur <= 1'b1;
                            st       <= ST_PLAN;
                        end
                    end else begin
                        last_q <= in_stop;
                        st     <= ST_SHOW;
                    end
                end
                ST_SHOW: begin
                    if (out_ready) begin
                        if (last_q) begin
                            st <= ST_FIN;
                        end else begin
                            cur <= held;
                            st  <= ST_PLAN;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign out_valid = (st == ST_SHOW);
    assign out_last  = last_q;
    assign done      = (st == ST_FIN);

endmodule

// File: rtl/align_traceback.sv
module align_traceback
    import atb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [IDX_W-1:0]   start_row,
    input  logic [IDX_W-1:0]   start_col,
    output logic               mem_rd_en,
    output logic [IDX_W-1:0]   mem_rd_row,
    output logic [IDX_W-1:0]   mem_rd_col,
    input  logic [1:0]         mem_dir,
    input  logic [SCORE_W-1:0] mem_score,
    input  logic [CHAR_W-1:0]  mem_row_ch,
    input  logic [CHAR_W-1:0]  mem_col_ch,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [CHAR_W-1:0]  out_row_ch,
    output logic [CHAR_W-1:0]  out_col_ch,
    output logic               out_last,
    output logic               done
);

    coord_t start_at;
    coord_t rd_at;
    cell_t  in_cell;
    cell_t  held;
    cell_t  cur;
    pair_t  pair;
    coord_t nxt;
    logic   in_stop;
    logic   nxt_edge;
    logic   cap_en;

    assign start_at.row = start_row;
    assign start_at.col = start_col;

    atb_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_at  (start_at),
        .in_cell   (in_cell),
        .in_stop   (in_stop),
        .held      (held),
        .nxt       (nxt),
        .nxt_edge  (nxt_edge),
        .out_ready (out_ready),
        .rd_en     (mem_rd_en),
        .rd_at     (rd_at),
        .cap_en    (cap_en),
        .cur       (cur),
        .out_valid (out_valid),
        .out_last  (out_last),
        .done      (done)
    );

    atb_cell_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .probe_at  (rd_at),
        .rsp_dir   (mem_dir),
        .rsp_score (mem_score),
        .rsp_rch   (mem_row_ch),
        .rsp_cch   (mem_col_ch),
        .in_cell   (in_cell),
        .in_stop   (in_stop),
        .held      (held)
    );

    atb_step_decode u_dec (
        .cur      (cur),
        .pair     (pair),
        .nxt      (nxt),
        .nxt_edge (nxt_edge)
    );

    assign mem_rd_row = rd_at.row;
    assign mem_rd_col = rd_at.col;
    assign out_row_ch = pair.rch;
    assign out_col_ch = pair.cch;

endmodule

// File: rtl/align_traceback_chk.sv
module align_traceback_chk
    import atb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_rd_en,
    input logic [IDX_W-1:0]  mem_rd_row,
    input logic [IDX_W-1:0]  mem_rd_col,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CHAR_W-1:0] out_row_ch,
    input logic [CHAR_W-1:0] out_col_ch,
    input logic              out_last,
    input logic              done
);

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row_ch)
                                       && $stable(out_col_ch) && $stable(out_last)));

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> done);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_mid_no_done: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> !done);

    a_r11_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    a_r5_no_border_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> ((mem_rd_row != '0) && (mem_rd_col != '0)));

    a_r12_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !done));

    a_r9_no_pair_with_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

endmodule

bind align_traceback align_traceback_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_row (mem_rd_row),
    .mem_rd_col (mem_rd_col),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_row_ch (out_row_ch),
    .out_col_ch (out_col_ch),
    .out_last   (out_last),
    .done       (done)
);

// File: tb/align_traceback_tb.sv
`timescale 1ns/1ps
module align_traceback_tb;
    import atb_pkg::*;

    localparam int N = 12;
    localparam logic [7:0] DASH = 8'h2D;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [IDX_W-1:0]   start_row = '0;
    logic [IDX_W-1:0]   start_col = '0;
    logic               mem_rd_en;
    logic [IDX_W-1:0]   mem_rd_row;
    logic [IDX_W-1:0]   mem_rd_col;
    logic [1:0]         mem_dir = '0;
    logic [SCORE_W-1:0] mem_score = '0;
    logic [CHAR_W-1:0]  mem_row_ch = '0;
    logic [CHAR_W-1:0]  mem_col_ch = '0;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic [CHAR_W-1:0]  out_row_ch;
    logic [CHAR_W-1:0]  out_col_ch;
    logic               out_last;
    logic               done;

    always #2 clk = ~clk;

    align_traceback u_dut (
        .clk(clk), .rst(rst), .start(start), .start_row(start_row), .start_col(start_col),
        .mem_rd_en(mem_rd_en), .mem_rd_row(mem_rd_row), .mem_rd_col(mem_rd_col),
        .mem_dir(mem_dir), .mem_score(mem_score), .mem_row_ch(mem_row_ch), .mem_col_ch(mem_col_ch),
        .out_valid(out_valid), .out_ready(out_ready), .out_row_ch(out_row_ch),
        .out_col_ch(out_col_ch), .out_last(out_last), .done(done)
    );

    logic [1:0] dm [0:N][0:N];
    int         sm [0:N][0:N];
    logic [7:0] ra [0:N];
    logic [7:0] cb [0:N];
    logic [7:0] exp_r [0:63];
    logic [7:0] exp_c [0:63];
    int exp_n;
    int checks = 0;
    int fails = 0;
    int bad_reads = 0;
    int cyc = 0;

    // Memory model: one cycle of read latency, junk when nothing was requested.
    always @(posedge clk) begin
        if (mem_rd_en && mem_rd_row <= N && mem_rd_col <= N) begin
            mem_dir    <= dm[mem_rd_row][mem_rd_col];
            mem_score  <= SCORE_W'(sm[mem_rd_row][mem_rd_col]);
            mem_row_ch <= ra[mem_rd_row];
            mem_col_ch <= cb[mem_rd_col];
        end else begin
            mem_dir    <= 2'b00;
            mem_score  <= '0;
            mem_row_ch <= 8'h3F;
            mem_col_ch <= 8'h3F;
        end
        if (!rst && mem_rd_en && (mem_rd_row == 0 || mem_rd_col == 0 || mem_rd_row > N || mem_rd_col > N))
            bad_reads <= bad_reads + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            chk(1'b0, "R9", "watchdog expired", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [7:0] base(input int k);
        case (k % 4)
            0: return 8'h41;
            1: return 8'h43;
            2: return 8'h47;
            default: return 8'h54;
        endcase
    endfunction

    task automatic fill_random();
        for (int i = 0; i <= N; i++) begin
            ra[i] = base($urandom_range(3));
            cb[i] = base($urandom_range(3));
            for (int j = 0; j <= N; j++) begin
                dm[i][j] = ($urandom_range(9) == 0) ? 2'b00 : 2'($urandom_range(3, 1));
                sm[i][j] = ($urandom_range(7) == 0) ? 0 : int'($urandom_range(60, 1));
            end
        end
    endtask

    // Reference walk written from R1, R3, R4, R5.
    task automatic build_expected(input int r0, input int c0);
        int r;
        int c;
        r = r0;
        c = c0;
        exp_n = 0;
        while (r != 0 && c != 0 && sm[r][c] != 0 && dm[r][c] != 2'b00) begin
            case (dm[r][c])
                2'b01: begin exp_r[exp_n] = ra[r]; exp_c[exp_n] = cb[c]; r--; c--; end
                2'b10: begin exp_r[exp_n] = ra[r]; exp_c[exp_n] = DASH;  r--; end
                default: begin exp_r[exp_n] = DASH; exp_c[exp_n] = cb[c]; c--; end
            endcase
            exp_n++;
        end
    endtask

    task automatic run_walk(input int r, input int c, input int rdy_pct,
                            input bit poke, input string tag);
        int got;
        int waitc;
        bit exp_done;
        bit seen_done;
        bit stalled;
        bit poked;
        logic [7:0] pr;
        logic [7:0] pc;
        logic pl;
        build_expected(r, c);
        @(negedge clk);
        start = 1'b1;
        start_row = IDX_W'(r);
        start_col = IDX_W'(c);
        @(negedge clk);
        start = 1'b0;
        got = 0; waitc = 0; exp_done = 0; seen_done = 0; stalled = 0; poked = 0;
        pr = '0; pc = '0; pl = 1'b0;
        while (!seen_done && waitc < 3000) begin
            start = 1'b0;
            if (exp_done) begin
                chk(done === 1'b1, "R9", {tag, " done after last pair"}, done, 1);
                seen_done = 1;
            end else if (done) begin
                chk(exp_n == 0 && got == 0, "R6", {tag, " done without pending pairs"}, got, exp_n);
                seen_done = 1;
            end else begin
                if (poke && !poked && got == 1) begin
                    // R10: foreign start while busy
                    start = 1'b1;
                    start_row = IDX_W'(2);
                    start_col = IDX_W'(2);
                    poked = 1;
                end
                if (stalled) begin
                    chk(out_valid && out_row_ch == pr && out_col_ch == pc && out_last == pl,
                        "R7", {tag, " stalled pair held"}, {out_row_ch, out_col_ch}, {pr, pc});
                end
                out_ready = ($urandom_range(99) < rdy_pct);
                stalled = 0;
                if (out_valid && out_ready) begin
                    if (got < exp_n) begin
                        chk(out_row_ch == exp_r[got] && out_col_ch == exp_c[got], "R1",
                            $sformatf("%s pair %0d", tag, got),
                            {out_row_ch, out_col_ch}, {exp_r[got], exp_c[got]});
                        chk(out_last == (got == exp_n - 1), "R8",
                            $sformatf("%s last flag on pair %0d", tag, got), out_last, (got == exp_n - 1));
                    end else begin
                        chk(1'b0, "R3", {tag, " extra pair"}, got, exp_n);
                    end
                    if (out_last) exp_done = 1;
                    got++;
                end else if (out_valid) begin
                    stalled = 1;
                    pr = out_row_ch; pc = out_col_ch; pl = out_last;
                end
                @(negedge clk);
                waitc++;
            end
        end
        start = 1'b0;
        out_ready = 1'b0;
        chk(seen_done, "R9", {tag, " done seen"}, seen_done, 1);
        chk(got == exp_n, "R2", {tag, " pair count"}, got, exp_n);
        @(negedge clk);
        chk(done == 1'b0, "R9", {tag, " done lasts one cycle"}, done, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        fill_random();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !done && !mem_rd_en, "R12", "idle after reset",
            {out_valid, done, mem_rd_en}, 0);

        // R6: start cell has zero score
        sm[5][5] = 0;
        run_walk(5, 5, 100, 0, "R6 zero start");

        // R5: starts on the border produce nothing
        run_walk(0, 7, 100, 0, "R5 row0 start");
        run_walk(4, 0, 100, 0, "R5 col0 start");

        // R4: stop code with nonzero score ends the walk
        dm[6][6] = 2'b01; sm[6][6] = 9;
        dm[5][5] = 2'b00; sm[5][5] = 7;
        run_walk(6, 6, 100, 0, "R4 stop code");

        // R3: up then left, then a zero-score cell
        dm[6][6] = 2'b10; sm[6][6] = 3;
        dm[5][6] = 2'b11; sm[5][6] = 2;
        dm[5][5] = 2'b01; sm[5][5] = 0;
        run_walk(6, 6, 50, 0, "R3 zero end");

        // R5: diagonal run into row 0 with nonzero scores
        for (int k = 1; k <= 3; k++) begin
            dm[k][k] = 2'b01;
            sm[k][k] = 10 + k;
        end
        run_walk(3, 3, 100, 0, "R5 reach origin");

        // R10: start pulse in mid walk is ignored
        dm[8][8] = 2'b01; sm[8][8] = 5;
        dm[7][7] = 2'b10; sm[7][7] = 5;
        dm[6][7] = 2'b11; sm[6][7] = 5;
        sm[6][6] = 0;
        run_walk(8, 8, 40, 1, "R10 busy start");

        // R2 / R11: random matrices, random start and backpressure
        for (int t = 0; t < 40; t++) begin
            int pct;
            fill_random();
            pct = (t % 3 == 0) ? 100 : ((t % 3 == 1) ? 60 : 30);
            run_walk(int'($urandom_range(N)), int'($urandom_range(N)), pct, 0, "R2 random");
        end

        chk(bad_reads == 0, "R5", "reads of border cells", bad_reads, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule